// File: doc/BRIEF.md
# Interrupt Cause Collector with Moderation and Delay Timers

This block gathers interrupt causes from the receive and transmit sides of a packet engine into a sticky pending vector. It filters them through an enable mask and drives one level-sensitive interrupt line toward the processor. A throttle interval limits how often the line may rise. The interval starts each time the line goes high. While it runs, ordinary causes stay pending and silent. A cause flagged as urgent passes through at once.

Each direction also has two delay timers. The per-packet timer restarts on every packet event. The absolute timer starts on the first event and ignores later ones. When either timer of a direction runs out, three things happen: both timers of that direction are cleared, a one-cycle descriptor writeback request is pulsed, and the direction's timer cause is posted as urgent. A transmit writeback completion posts the transmit cause as an ordinary, throttled cause. All timer values count in units of 1024 ns. The `UNIT_CYCLES` parameter gives the number of clock cycles in one unit: 256 at 250 MHz.

Top module: `irq_moderator`

## Requirements
- R1: After reset the line is low, the pending vector is zero, both writeback requests are low and every mask bit is cleared.
- R2: A `cause_vld` strobe sets the bits of `cause_vec` in `pend` at the next clock edge, whatever the mask. A masked cause leaves the line low.
- R3: With the throttle idle, an unmasked cause posted in one cycle raises `irq` at the next clock edge.
- R4: `pend_rd` clears the pending vector at the next edge, but a cause posted in the same cycle survives. The line falls in that same edge once no unmasked cause remains.
- R5: Mask writes act at the next edge. A set that uncovers a pending cause raises the line when the throttle allows it. A clear that hides the last unmasked cause drops the line. When one bit is both set and cleared in the same cycle, the clear wins. `irq` high always implies an unmasked pending bit.
- R6: When `irq` rises, the throttle runs for `thr_ival*UNIT_CYCLES` cycles. While it runs, ordinary causes do not raise the line. A cause held this way raises the line one edge after the throttle ends.
- R7: A cause posted with `cause_now` raises the line at the next edge even while the throttle runs.
- R8: Receive per-packet timer: every `rx_pkt_evt` reloads it. It expires `rx_pkt_dly*UNIT_CYCLES` edges after the last event. On expiry `rx_wb_req` pulses for one cycle and bit `RXT_BIT` (default 7) of `pend` is set as an urgent cause.
- R9: Receive absolute timer: it starts on an event while idle and is not reloaded by later events. It expires `rx_abs_dly*UNIT_CYCLES` edges after the starting event, with the same effects as R8.
- R10: Transmit timers behave as in R8 and R9, using `tx_pkt_evt`. On expiry they pulse `tx_wb_req` and set bit `TXDW_BIT` (default 0) as an urgent cause.
- R11: `tx_wb_done` posts bit `TXDW_BIT` as an ordinary cause, which is held back by a running throttle.
- R12: A delay or throttle value of zero disables that timer: events start nothing and no writeback request follows.
- R13: Expiry of either timer of one direction clears both timers of that direction, so the other timer produces no later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_vld | input | 1 | Cause post strobe |
| cause_vec | input | NCAUSE | Causes to post |
| cause_now | input | 1 | Posted causes bypass the throttle |
| mask_set_vld | input | 1 | Mask set strobe |
| mask_set_bits | input | NCAUSE | Mask bits to enable |
| mask_clr_vld | input | 1 | Mask clear strobe |
| mask_clr_bits | input | NCAUSE | Mask bits to disable |
| pend_rd | input | 1 | Read-to-clear of the pending vector |
| thr_ival | input | TMR_W | Throttle interval in units |
| rx_pkt_dly | input | TMR_W | Receive per-packet delay in units |
| rx_abs_dly | input | TMR_W | Receive absolute delay in units |
| tx_pkt_dly | input | TMR_W | Transmit per-packet delay in units |
| tx_abs_dly | input | TMR_W | Transmit absolute delay in units |
| rx_pkt_evt | input | 1 | Receive packet event |
| tx_pkt_evt | input | 1 | Transmit packet event |
| tx_wb_done | input | 1 | Transmit descriptor writeback completed |
| pend | output | NCAUSE | Pending cause vector |
| rx_wb_req | output | 1 | Receive writeback request pulse |
| tx_wb_req | output | 1 | Transmit writeback request pulse |
| irq | output | 1 | Interrupt line to the processor |

## Verification
The hardest state to reach from the ports is a throttle interval that is still running while the line is low and a fresh ordinary cause is pending. To get there, the stimulus raises the line with one cause, which starts the interval. It then clears the line with a read and posts a second cause, and the exact edge where the held cause finally drives the line is predicted. The same open interval is then used to show that an urgent cause, a transmit timer expiry and a writeback completion each behave in their own way. A second tricky case is a pair of timers racing in one direction: the shorter absolute timer must cancel the longer per-packet timer, and no second request may follow.

// File: rtl/irq_mod_pkg.sv
`timescale 1ns/1ps
package irq_mod_pkg;
   // timer flavours selected at elaboration
   localparam int TMR_ONESHOT = 0;   // started only while idle
   localparam int TMR_RETRIG  = 1;   // reloaded on every trigger
   // direction indices
   localparam int DIR_RX = 0;
   localparam int DIR_TX = 1;
   localparam int NDIR   = 2;
   // timers per direction: index 0 per-packet, index 1 absolute
   localparam int NTMR   = 2;

   function automatic int tmr_mode_of(input int idx);
      return (idx == 0) ? TMR_RETRIG : TMR_ONESHOT;
   endfunction
endpackage

// File: rtl/irq_dly_timer.sv
`timescale 1ns/1ps
module irq_dly_timer #(
   parameter int VAL_W       = 16,
   parameter int UNIT_CYCLES = 256,
   parameter int MODE        = irq_mod_pkg::TMR_ONESHOT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] dly_val,
   input  logic             trig,
   input  logic             cancel,
   output logic             expire,
   output logic             busy
);
   localparam int UNIT_W = $clog2(UNIT_CYCLES + 1);
   localparam int CNT_W  = VAL_W + UNIT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_cyc;
   logic             enabled;
   logic             start;

   assign enabled  = (dly_val != '0);
   assign load_cyc = CNT_W'(dly_val) * CNT_W'(UNIT_CYCLES);
   assign expire   = (cnt_q == CNT_W'(1));
   assign busy     = (cnt_q != '0);

   generate
      if (MODE == irq_mod_pkg::TMR_RETRIG) begin : g_retrig
         assign start = trig & enabled;
      end else begin : g_oneshot
         assign start = trig & enabled & (~busy | cancel | expire);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enabled) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load_cyc;
      end else if (cancel) begin
         cnt_q <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/irq_delay_path.sv
`timescale 1ns/1ps
module irq_delay_path #(
   parameter int VAL_W       = 16,
   parameter int UNIT_CYCLES = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] pkt_val,
   input  logic [VAL_W-1:0] abs_val,
   input  logic             evt,
   output logic             expire_any,
   output logic             busy_any,
   output logic             wb_req_q
);
   localparam int NT = irq_mod_pkg::NTMR;

   logic [NT-1:0][VAL_W-1:0] vals;
   logic [NT-1:0]            exp_v;
   logic [NT-1:0]            busy_v;

   assign vals       = {abs_val, pkt_val};
   assign expire_any = |exp_v;
   assign busy_any   = |busy_v;

   for (genvar k = 0; k < NT; k++) begin : g_tmr
      irq_dly_timer #(
         .VAL_W      (VAL_W),
         .UNIT_CYCLES(UNIT_CYCLES),
         .MODE       (irq_mod_pkg::tmr_mode_of(k))
      ) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .dly_val(vals[k]),
         .trig   (evt),
         .cancel (expire_any),
         .expire (exp_v[k]),
         .busy   (busy_v[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_req_q <= 1'b0;
      end else begin
         wb_req_q <= expire_any;
      end
   end
endmodule

// File: rtl/irq_cause_core.sv
`timescale 1ns/1ps
module irq_cause_core #(
   parameter int NCAUSE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAUSE-1:0] post_vec,
   input  logic [NCAUSE-1:0] now_vec,
   input  logic              set_vld,
   input  logic [NCAUSE-1:0] set_bits,
   input  logic              clr_vld,
   input  logic [NCAUSE-1:0] clr_bits,
   input  logic              rd_clr,
   input  logic              thr_busy,
   output logic [NCAUSE-1:0] pend_q,
   output logic [NCAUSE-1:0] mask_q,
   output logic              irq_q,
   output logic              irq_rise,
   output logic              now_hit,
   output logic              unmask_any
);
   logic [NCAUSE-1:0] pend_d;
   logic [NCAUSE-1:0] mask_d;
   logic              irq_d;

   always_comb begin
      pend_d = (rd_clr ? '0 : pend_q) | post_vec;
      mask_d = mask_q;
      if (set_vld) mask_d = mask_d | set_bits;
      if (clr_vld) mask_d = mask_d & ~clr_bits;
   end

   assign unmask_any = |(pend_d & mask_d);
   assign now_hit    = |(now_vec & mask_d);
   assign irq_d      = unmask_any & (irq_q | now_hit | ~thr_busy);
   assign irq_rise   = irq_d & ~irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         mask_q <= mask_d;
         irq_q  <= irq_d;
      end
   end
endmodule

// File: rtl/irq_moderator.sv
`timescale 1ns/1ps
module irq_moderator #(
   parameter int NCAUSE      = 8,
   parameter int TMR_W       = 16,
   parameter int UNIT_CYCLES = 256,
   parameter int RXT_BIT     = 7,
   parameter int TXDW_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cause_vld,
   input  logic [NCAUSE-1:0] cause_vec,
   input  logic              cause_now,
   input  logic              mask_set_vld,
   input  logic [NCAUSE-1:0] mask_set_bits,
   input  logic              mask_clr_vld,
   input  logic [NCAUSE-1:0] mask_clr_bits,
   input  logic              pend_rd,
   input  logic [TMR_W-1:0]  thr_ival,
   input  logic [TMR_W-1:0]  rx_pkt_dly,
   input  logic [TMR_W-1:0]  rx_abs_dly,
   input  logic [TMR_W-1:0]  tx_pkt_dly,
   input  logic [TMR_W-1:0]  tx_abs_dly,
   input  logic              rx_pkt_evt,
   input  logic              tx_pkt_evt,
   input  logic              tx_wb_done,
   output logic [NCAUSE-1:0] pend,
   output logic              rx_wb_req,
   output logic              tx_wb_req,
   output logic              irq
);
   localparam int ND = irq_mod_pkg::NDIR;

   if (NCAUSE < 2) begin : g_chk_ncause
      $error("irq_moderator: NCAUSE must be at least 2");
   end
   if (TMR_W < 1 || UNIT_CYCLES < 1) begin : g_chk_tmr
      $error("irq_moderator: timer width and unit length must be positive");
   end
   if (RXT_BIT >= NCAUSE || TXDW_BIT >= NCAUSE || RXT_BIT == TXDW_BIT) begin : g_chk_bits
      $error("irq_moderator: timer cause bits must be distinct and in range");
   end

   logic [ND-1:0][TMR_W-1:0] pkt_vals;
   logic [ND-1:0][TMR_W-1:0] abs_vals;
   logic [ND-1:0]            dir_evt;
   logic [ND-1:0]            dir_exp;
   logic [ND-1:0]            dir_busy;
   logic [ND-1:0]            dir_req;

   assign pkt_vals = {tx_pkt_dly, rx_pkt_dly};
   assign abs_vals = {tx_abs_dly, rx_abs_dly};
   assign dir_evt  = {tx_pkt_evt, rx_pkt_evt};

   for (genvar d = 0; d < ND; d++) begin : g_dir
      irq_delay_path #(
         .VAL_W      (TMR_W),
         .UNIT_CYCLES(UNIT_CYCLES)
      ) u_path (
         .clk       (clk),
         .rst_n     (rst_n),
         .pkt_val   (pkt_vals[d]),
         .abs_val   (abs_vals[d]),
         .evt       (dir_evt[d]),
         .expire_any(dir_exp[d]),
         .busy_any  (dir_busy[d]),
         .wb_req_q  (dir_req[d])
      );
   end

   logic rx_busy;
   logic tx_busy;
   assign rx_busy   = dir_busy[irq_mod_pkg::DIR_RX];
   assign tx_busy   = dir_busy[irq_mod_pkg::DIR_TX];
   assign rx_wb_req = dir_req[irq_mod_pkg::DIR_RX];
   assign tx_wb_req = dir_req[irq_mod_pkg::DIR_TX];

   // cause merge: external strobe plus timer expiries and writeback completion
   logic [NCAUSE-1:0] post_vec;
   logic [NCAUSE-1:0] now_vec;

   always_comb begin
      post_vec = cause_vld ? cause_vec : '0;
      now_vec  = (cause_vld && cause_now) ? cause_vec : '0;
      if (dir_exp[irq_mod_pkg::DIR_RX]) begin
         post_vec[RXT_BIT] = 1'b1;
         now_vec[RXT_BIT]  = 1'b1;
      end
      if (dir_exp[irq_mod_pkg::DIR_TX]) begin
         post_vec[TXDW_BIT] = 1'b1;
         now_vec[TXDW_BIT]  = 1'b1;
      end
      if (tx_wb_done) begin
         post_vec[TXDW_BIT] = 1'b1;
      end
   end

   logic              thr_busy;
   logic              thr_expire;
   logic              irq_rise;
   logic              now_hit;
   logic              unmask_any;
   logic [NCAUSE-1:0] mask_q;

   irq_dly_timer #(
      .VAL_W      (TMR_W),
      .UNIT_CYCLES(UNIT_CYCLES),
      .MODE       (irq_mod_pkg::TMR_ONESHOT)
   ) u_throttle (
      .clk    (clk),
      .rst_n  (rst_n),
      .dly_val(thr_ival),
      .trig   (irq_rise),
      .cancel (1'b0),
      .expire (thr_expire),
      .busy   (thr_busy)
   );

   irq_cause_core #(
      .NCAUSE(NCAUSE)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .post_vec  (post_vec),
      .now_vec   (now_vec),
      .set_vld   (mask_set_vld),
      .set_bits  (mask_set_bits),
      .clr_vld   (mask_clr_vld),
      .clr_bits  (mask_clr_bits),
      .rd_clr    (pend_rd),
      .thr_busy  (thr_busy),
      .pend_q    (pend),
      .mask_q    (mask_q),
      .irq_q     (irq),
      .irq_rise  (irq_rise),
      .now_hit   (now_hit),
      .unmask_any(unmask_any)
   );
endmodule

// File: rtl/irq_moderator_chk.sv
`timescale 1ns/1ps
module irq_moderator_chk #(
   parameter int NCAUSE   = 8,
   parameter int RXT_BIT  = 7,
   parameter int TXDW_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cause_vld,
   input logic [NCAUSE-1:0] cause_vec,
   input logic              pend_rd,
   input logic              rx_pkt_evt,
   input logic [NCAUSE-1:0] post_vec,
   input logic [NCAUSE-1:0] pend,
   input logic [NCAUSE-1:0] mask_q,
   input logic              irq,
   input logic              irq_rise,
   input logic              rx_wb_req,
   input logic              tx_wb_req,
   input logic              rx_busy,
   input logic              thr_busy,
   input logic              thr_expire,
   input logic              now_hit
);
   assert_cause_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cause_vld |=> ((pend & $past(cause_vec)) == $past(cause_vec)));

   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_rd |=> (pend == $past(post_vec)));

   assert_line_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((pend & mask_q) != '0));

   assert_throttle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && thr_busy && !now_hit) |=> !irq);

   assert_throttle_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_expire && !irq_rise) |=> !thr_busy);

   assert_urgent_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      now_hit |=> irq);

   assert_rx_req_posts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wb_req |-> pend[RXT_BIT]);

   assert_tx_req_posts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wb_req |-> pend[TXDW_BIT]);

   assert_pair_cancel_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wb_req && !$past(rx_pkt_evt)) |-> !rx_busy);
endmodule

bind irq_moderator irq_moderator_chk #(
   .NCAUSE  (NCAUSE),
   .RXT_BIT (RXT_BIT),
   .TXDW_BIT(TXDW_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cause_vld (cause_vld),
   .cause_vec (cause_vec),
   .pend_rd   (pend_rd),
   .rx_pkt_evt(rx_pkt_evt),
   .post_vec  (post_vec),
   .pend      (pend),
   .mask_q    (mask_q),
   .irq       (irq),
   .irq_rise  (irq_rise),
   .rx_wb_req (rx_wb_req),
   .tx_wb_req (tx_wb_req),
   .rx_busy   (rx_busy),
   .thr_busy  (thr_busy),
   .thr_expire(thr_expire),
   .now_hit   (now_hit)
);

// File: tb/irq_moderator_test.sv
`timescale 1ns/1ps
module irq_moderator_test;
   localparam int NC = 8;
   localparam int TW = 16;
   localparam int UC = 4;
   localparam int F_IRQ = 0;
   localparam int F_PEND = 1;
   localparam int F_RXW = 2;
   localparam int F_TXW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cause_vld = 1'b0, cause_now = 1'b0;
   logic [NC-1:0] cause_vec = '0;
   logic mask_set_vld = 1'b0, mask_clr_vld = 1'b0;
   logic [NC-1:0] mask_set_bits = '0, mask_clr_bits = '0;
   logic pend_rd = 1'b0;
   logic [TW-1:0] thr_ival = '0, rx_pkt_dly = '0, rx_abs_dly = '0;
   logic [TW-1:0] tx_pkt_dly = '0, tx_abs_dly = '0;
   logic rx_pkt_evt = 1'b0, tx_pkt_evt = 1'b0, tx_wb_done = 1'b0;
   logic [NC-1:0] pend;
   logic rx_wb_req, tx_wb_req, irq;

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   irq_moderator #(
      .NCAUSE(NC), .TMR_W(TW), .UNIT_CYCLES(UC), .RXT_BIT(7), .TXDW_BIT(0)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .cause_vld(cause_vld), .cause_vec(cause_vec), .cause_now(cause_now),
      .mask_set_vld(mask_set_vld), .mask_set_bits(mask_set_bits),
      .mask_clr_vld(mask_clr_vld), .mask_clr_bits(mask_clr_bits),
      .pend_rd(pend_rd), .thr_ival(thr_ival),
      .rx_pkt_dly(rx_pkt_dly), .rx_abs_dly(rx_abs_dly),
      .tx_pkt_dly(tx_pkt_dly), .tx_abs_dly(tx_abs_dly),
      .rx_pkt_evt(rx_pkt_evt), .tx_pkt_evt(tx_pkt_evt), .tx_wb_done(tx_wb_done),
      .pend(pend), .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req), .irq(irq)
   );

   // scoreboard: expected observation at an absolute cycle
   typedef struct {
      int         at;
      int         fld;
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t sbq[$];

   function automatic logic [7:0] observe(input int f);
      case (f)
         F_IRQ:   return {7'b0, irq};
         F_PEND:  return pend;
         F_RXW:   return {7'b0, rx_wb_req};
         default: return {7'b0, tx_wb_req};
      endcase
   endfunction

   function automatic string fname(input int f);
      case (f)
         F_IRQ:   return "irq";
         F_PEND:  return "pend";
         F_RXW:   return "rx_wb_req";
         default: return "tx_wb_req";
      endcase
   endfunction

   task automatic expect_at(input int ofs, input int f, input logic [7:0] v, input string tag);
      exp_t e;
      e.at = cyc + ofs;
      e.fld = f;
      e.val = v;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: outputs are all registered, so they are stable at the falling edge
   always @(negedge clk) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
         if (sbq[i].at == cyc) begin
            n_tests++;
            if (observe(sbq[i].fld) !== sbq[i].val) begin
               n_fail++;
               $display("FAIL %s: %s got %0h expected %0h at cycle %0d",
                        sbq[i].tag, fname(sbq[i].fld), observe(sbq[i].fld),
                        sbq[i].val, cyc);
            end
            sbq.delete(i);
         end
      end
   end

   task automatic nb();
      @(negedge clk);
   endtask

   task automatic step();
      @(negedge clk);
      cause_vld = 1'b0; cause_now = 1'b0;
      mask_set_vld = 1'b0; mask_clr_vld = 1'b0;
      pend_rd = 1'b0; rx_pkt_evt = 1'b0; tx_pkt_evt = 1'b0; tx_wb_done = 1'b0;
   endtask

   task automatic post(input logic [NC-1:0] v, input bit now);
      cause_vld = 1'b1; cause_vec = v; cause_now = now;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (3) nb();
      rst_n = 1'b1;

      // R1 reset state
      expect_at(1, F_IRQ, 8'h00, "R1");
      expect_at(1, F_PEND, 8'h00, "R1");
      expect_at(1, F_RXW, 8'h00, "R1");
      expect_at(1, F_TXW, 8'h00, "R1");
      step();

      // R2 masked cause is recorded but silent (mask all zero after reset)
      post(8'h04, 1'b0);
      expect_at(1, F_PEND, 8'h04, "R2");
      expect_at(1, F_IRQ, 8'h00, "R2");
      expect_at(2, F_IRQ, 8'h00, "R2");
      step(); step();

      // R3 and R5: uncovering a pending cause raises the line next edge
      mask_set_vld = 1'b1; mask_set_bits = 8'h04;
      expect_at(1, F_IRQ, 8'h01, "R3");
      step();

      // R4 read clears pending and drops the line
      pend_rd = 1'b1;
      expect_at(1, F_PEND, 8'h00, "R4");
      expect_at(1, F_IRQ, 8'h00, "R4");
      step();

      // R4 cause posted with the read survives
      pend_rd = 1'b1; post(8'h04, 1'b0);
      expect_at(1, F_PEND, 8'h04, "R4");
      expect_at(1, F_IRQ, 8'h01, "R4");
      step();

      // R5 clearing the mask drops the line, pending stays
      mask_clr_vld = 1'b1; mask_clr_bits = 8'h04;
      expect_at(1, F_IRQ, 8'h00, "R5");
      expect_at(1, F_PEND, 8'h04, "R5");
      step();

      // R5 set and clear of one bit together: clear wins
      mask_set_vld = 1'b1; mask_set_bits = 8'h04;
      mask_clr_vld = 1'b1; mask_clr_bits = 8'h04;
      expect_at(1, F_IRQ, 8'h00, "R5");
      expect_at(2, F_IRQ, 8'h00, "R5");
      step(); step();
      mask_set_vld = 1'b1; mask_set_bits = 8'h04;
      expect_at(1, F_IRQ, 8'h01, "R5");
      step();
      pend_rd = 1'b1;
      expect_at(1, F_IRQ, 8'h00, "R4");
      step();

      // R6 throttle of 3 units = 12 cycles holds an ordinary cause
      thr_ival = 16'd3;
      post(8'h04, 1'b0);
      expect_at(1, F_IRQ, 8'h01, "R6");
      step();
      pend_rd = 1'b1;
      expect_at(1, F_IRQ, 8'h00, "R6");
      step();
      post(8'h04, 1'b0);
      expect_at(1, F_IRQ, 8'h00, "R6");
      expect_at(11, F_IRQ, 8'h00, "R6");
      expect_at(12, F_IRQ, 8'h01, "R6");
      expect_at(12, F_PEND, 8'h04, "R6");
      step();
      repeat (11) nb();
      pend_rd = 1'b1;
      expect_at(1, F_IRQ, 8'h00, "R6");
      step();

      // R7 urgent cause passes a running throttle
      post(8'h04, 1'b1);
      expect_at(1, F_IRQ, 8'h01, "R7");
      step();
      pend_rd = 1'b1;
      expect_at(1, F_IRQ, 8'h00, "R7");
      thr_ival = '0;
      step();
      repeat (3) nb();

      // enable both timer causes
      mask_set_vld = 1'b1; mask_set_bits = 8'h81;
      step();

      // R8 receive per-packet timer reloads on each event (5 units = 20 cycles)
      rx_pkt_dly = 16'd5;
      rx_pkt_evt = 1'b1;
      step();
      repeat (9) nb();
      rx_pkt_evt = 1'b1;
      expect_at(11, F_RXW, 8'h00, "R8");
      expect_at(21, F_RXW, 8'h01, "R8");
      expect_at(21, F_PEND, 8'h80, "R8");
      expect_at(21, F_IRQ, 8'h01, "R8");
      expect_at(22, F_RXW, 8'h00, "R8");
      step();
      repeat (22) nb();
      pend_rd = 1'b1;
      rx_pkt_dly = '0;
      step();

      // R9 absolute timer ignores later events
      rx_abs_dly = 16'd5;
      rx_pkt_evt = 1'b1;
      expect_at(21, F_RXW, 8'h01, "R9");
      expect_at(21, F_PEND, 8'h80, "R9");
      expect_at(22, F_RXW, 8'h00, "R9");
      step();
      repeat (9) nb();
      rx_pkt_evt = 1'b1;
      expect_at(21, F_RXW, 8'h00, "R9");
      step();
      repeat (25) nb();
      pend_rd = 1'b1;
      rx_abs_dly = '0;
      step();

      // R10 transmit timer expiry is urgent inside a running throttle
      thr_ival = 16'd3;
      tx_pkt_dly = 16'd2;
      post(8'h04, 1'b0);
      expect_at(1, F_IRQ, 8'h01, "R10");
      step();
      pend_rd = 1'b1;
      expect_at(1, F_IRQ, 8'h00, "R10");
      step();
      tx_pkt_evt = 1'b1;
      expect_at(8, F_IRQ, 8'h00, "R10");
      expect_at(9, F_TXW, 8'h01, "R10");
      expect_at(9, F_PEND, 8'h01, "R10");
      expect_at(9, F_IRQ, 8'h01, "R10");
      expect_at(10, F_TXW, 8'h00, "R10");
      step();
      repeat (10) nb();
      pend_rd = 1'b1;
      tx_pkt_dly = '0;
      step();
      repeat (15) nb();

      // R11 writeback completion is an ordinary cause, held by the throttle
      post(8'h04, 1'b0);
      expect_at(1, F_IRQ, 8'h01, "R11");
      step();
      pend_rd = 1'b1;
      step();
      tx_wb_done = 1'b1;
      expect_at(1, F_PEND, 8'h01, "R11");
      expect_at(1, F_IRQ, 8'h00, "R11");
      expect_at(11, F_IRQ, 8'h00, "R11");
      expect_at(12, F_IRQ, 8'h01, "R11");
      step();
      repeat (12) nb();
      pend_rd = 1'b1;
      thr_ival = '0;
      step();
      repeat (3) nb();

      // R12 zero values start nothing
      tx_pkt_evt = 1'b1;
      expect_at(2, F_TXW, 8'h00, "R12");
      expect_at(9, F_TXW, 8'h00, "R12");
      expect_at(9, F_PEND, 8'h00, "R12");
      step();
      repeat (10) nb();

      // R13 absolute (3 units) expiry cancels per-packet (5 units)
      rx_pkt_dly = 16'd5;
      rx_abs_dly = 16'd3;
      rx_pkt_evt = 1'b1;
      expect_at(13, F_RXW, 8'h01, "R13");
      expect_at(13, F_PEND, 8'h80, "R13");
      expect_at(14, F_RXW, 8'h00, "R13");
      expect_at(21, F_RXW, 8'h00, "R13");
      expect_at(22, F_RXW, 8'h00, "R13");
      step();
      repeat (25) nb();

      while (sbq.size() != 0) nb();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule